// File: doc/BRIEF.md
# Dual-Mode 8-bit PWM Timer

An 8-bit timer that drives a pulse-width-modulated pin. The counter moves in one of two shapes. In sawtooth (single-slope) mode it climbs from zero to the maximum value and then wraps to zero. In triangle (dual-slope) mode it climbs to the maximum and then descends back to zero. A compare value sets the duty cycle. A two-bit output-mode field selects whether a compare match drives the pin low or high, or whether the pin is left disconnected. Software reaches the block through a small register write port. A control register holds the two mode fields and the two interrupt enables, and a compare register holds the duty value.

Writes to the compare register are double-buffered. While the counter runs, a new value takes effect only at the maximum count, so a period is never cut short by a glitch. The block keeps a compare-match flag and an overflow flag. Each flag has its own enable that gates its interrupt request line, and a separate acknowledge input clears each flag when its service routine is entered.

The counter advances once per clock while a counting mode is selected. Clock prescaling, pin direction and interrupt vectoring live outside this block.

Top module: `pwm_tc`

## Requirements
- R1: After reset, count_o is 0, both flags and both interrupt lines are 0, pwm_o and pwm_oe are 0, the control register is 0 and the active compare value is 0.
- R2: Control bits [1:0] select the wave mode. With wave mode 00 or 01 the counter holds its value and neither flag is set.
- R3: With wave mode 11 (sawtooth), count_o rises by one on every clock and wraps from 255 to 0.
- R4: With wave mode 10 (triangle), count_o rises from 0 to 255, then falls by one per clock back to 0, and then rises again, for a period of 510 clocks.
- R5: The compare flag (cmp_flag_o) becomes 1 on the clock edge that ends a cycle in which a counting mode is active and count_o equals the active compare value.
- R6: The overflow flag (ovf_flag_o) becomes 1 on the edge that ends a cycle with count_o at 255 in sawtooth mode. In triangle mode it becomes 1 on the edge that ends the cycle in which the descending count reaches 0.
- R7: cmp_irq is cmp_flag_o gated by control bit 4, and ovf_irq is ovf_flag_o gated by control bit 5.
- R8: A high cmp_ack or ovf_ack clears its flag on the next edge. If the flag's set condition falls in the same cycle, the flag stays set.
- R9: In sawtooth mode with compare value k, pwm_o is high for k clocks of every 256 when output mode (control bits [3:2]) is 10, which clears on match and sets at zero. It is high for 256-k clocks when the output mode is 11.
- R10: In triangle mode with compare value k, pwm_o is high for 2k clocks of every 510 when the output mode is 10, which clears on an up-count match and sets on a down-count match. It is high for 510-2k clocks when the output mode is 11.
- R11: Register address 1 writes the compare buffer. While counting, the buffer moves to the active compare value on the edge that ends the cycle with count_o at 255 (in both modes). While halted, it moves on the next edge.
- R12: With output mode 00 or 01, pwm_oe is 0 and pwm_o stays 0. With 10 or 11, pwm_oe is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one count per edge while running |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 selects control, 1 selects compare buffer |
| wr_data | input | 8 | Write data; control uses bits [5:0] |
| cmp_ack | input | 1 | Clears the compare flag (service entry) |
| ovf_ack | input | 1 | Clears the overflow flag (service entry) |
| count_o | output | 8 | Current counter value |
| pwm_o | output | 1 | Waveform pin level, 0 when disconnected |
| pwm_oe | output | 1 | Pin drive enable |
| cmp_flag_o | output | 1 | Compare-match flag |
| ovf_flag_o | output | 1 | Overflow flag |
| cmp_irq | output | 1 | Compare interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |

## Verification
A flag's set event and its acknowledge can fall in the same cycle. The bench provokes this by waiting until count_o shows the compare value, or the bottom of the triangle, and then raising the acknowledge in that very cycle. A correct design leaves the flag high on the next cycle, while a design that gives the acknowledge priority drops it. In sawtooth mode the match and the bottom-of-period set also collide when the compare value is 0. The duty sweep judges this from the high-cycle count, which must be zero.

// File: rtl/pwm_tc_pkg.sv
package pwm_tc_pkg;

  typedef enum logic [1:0] {
    WM_STOP_A = 2'b00,
    WM_STOP_B = 2'b01,
    WM_DUAL   = 2'b10,
    WM_FAST   = 2'b11
  } wave_mode_e;

  typedef enum logic [1:0] {
    OM_OFF   = 2'b00,
    OM_RSVD  = 2'b01,
    OM_CLEAR = 2'b10,
    OM_SET   = 2'b11
  } out_mode_e;

  typedef struct packed {
    logic       ovf_ie;
    logic       cmp_ie;
    out_mode_e  om;
    wave_mode_e wm;
  } ctrl_t;

  localparam int CTRL_W  = 6;
  localparam int N_FLAG  = 2;
  localparam int FLG_CMP = 0;
  localparam int FLG_OVF = 1;

endpackage

// File: rtl/pwm_tc_regs.sv
module pwm_tc_regs
  import pwm_tc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         running,
  input  logic         at_top,
  output ctrl_t        ctrl_q,
  output logic [W-1:0] cmp_act
);

  logic [W-1:0] cmp_buf;
  logic         load_act;
  logic         unused_hi;

  assign load_act  = !running || at_top;
  assign unused_hi = &{1'b0, wr_data[W-1:CTRL_W]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q  <= ctrl_t'('0);
      cmp_buf <= '0;
      cmp_act <= '0;
    end else begin
      if (wr_en && !wr_addr) ctrl_q  <= ctrl_t'(wr_data[CTRL_W-1:0]);
      if (wr_en &&  wr_addr) cmp_buf <= wr_data;
      if (load_act)          cmp_act <= cmp_buf;
    end
  end

endmodule

// File: rtl/pwm_tc_counter.sv
module pwm_tc_counter
  import pwm_tc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [1:0]   wm,
  output logic [W-1:0] cnt,
  output logic         step_up,
  output logic         at_top,
  output logic         at_bottom,
  output logic         running,
  output logic         fast,
  output logic         ovf_evt
);

  localparam logic [W-1:0] MAXV = '1;

  logic dir_q;

  function automatic logic [W-1:0] next_count(input logic [W-1:0] c,
                                              input logic fast_m,
                                              input logic up);
    if (fast_m || up) return c + 1'b1;
    return c - 1'b1;
  endfunction

  assign fast      = (wm == WM_FAST);
  assign running   = fast || (wm == WM_DUAL);
  assign at_top    = (cnt == MAXV);
  assign at_bottom = (cnt == '0);
  assign step_up   = at_bottom ? 1'b1 : (at_top ? 1'b0 : dir_q);
  assign ovf_evt   = running && (fast ? at_top : (at_bottom && !dir_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      dir_q <= 1'b1;
    end else if (running) begin
      cnt   <= next_count(cnt, fast, step_up);
      dir_q <= fast | step_up;
    end
  end

endmodule

// File: rtl/pwm_tc_wave.sv
module pwm_tc_wave #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         running,
  input  logic         fast,
  input  logic [1:0]   om,
  input  logic [W-1:0] cnt,
  input  logic [W-1:0] cmp_act,
  input  logic         step_up,
  input  logic         at_bottom,
  output logic         cmp_evt,
  output logic         pwm_o,
  output logic         pwm_oe
);

  logic wave_q;

  function automatic logic next_level(input logic cur, input logic match,
                                      input logic bottom, input logic fast_m,
                                      input logic up, input logic drive);
    if (match) return (fast_m || up) ? drive : ~drive;
    if (fast_m && bottom) return ~drive;
    return cur;
  endfunction

  assign cmp_evt = running && (cnt == cmp_act);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wave_q <= 1'b0;
    else if (running)
      wave_q <= next_level(wave_q, cmp_evt, at_bottom, fast, step_up, om[0]);
  end

  assign pwm_oe = om[1];
  assign pwm_o  = pwm_oe & wave_q;

endmodule

// File: rtl/pwm_tc_flag.sv
module pwm_tc_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic ack,
  input  logic enable,
  output logic flag_q,
  output logic irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flag_q <= 1'b0;
    else        flag_q <= set_evt | (flag_q & ~ack);
  end

  assign irq = flag_q & enable;

endmodule

// File: rtl/pwm_tc.sv
module pwm_tc
  import pwm_tc_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic         wr_addr,
  input  logic [W-1:0] wr_data,
  input  logic         cmp_ack,
  input  logic         ovf_ack,
  output logic [W-1:0] count_o,
  output logic         pwm_o,
  output logic         pwm_oe,
  output logic         cmp_flag_o,
  output logic         ovf_flag_o,
  output logic         cmp_irq,
  output logic         ovf_irq
);

  ctrl_t        ctrl_q;
  logic [W-1:0] cmp_act;
  logic [1:0]   wm_w;
  logic         step_up, at_top, at_bottom, running, fast;
  logic         cmp_evt_w, ovf_evt_w;

  logic [N_FLAG-1:0] evt_v, ack_v, ie_v, flag_v, irq_v;

  assign wm_w = ctrl_q.wm;

  pwm_tc_regs #(.W(W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .running(running), .at_top(at_top),
    .ctrl_q(ctrl_q), .cmp_act(cmp_act)
  );

  pwm_tc_counter #(.W(W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .wm(wm_w), .cnt(count_o),
    .step_up(step_up), .at_top(at_top), .at_bottom(at_bottom),
    .running(running), .fast(fast), .ovf_evt(ovf_evt_w)
  );

  pwm_tc_wave #(.W(W)) u_wave (
    .clk(clk), .rst_n(rst_n), .running(running), .fast(fast),
    .om(ctrl_q.om), .cnt(count_o), .cmp_act(cmp_act), .step_up(step_up),
    .at_bottom(at_bottom), .cmp_evt(cmp_evt_w), .pwm_o(pwm_o), .pwm_oe(pwm_oe)
  );

  assign evt_v[FLG_CMP] = cmp_evt_w;
  assign evt_v[FLG_OVF] = ovf_evt_w;
  assign ack_v[FLG_CMP] = cmp_ack;
  assign ack_v[FLG_OVF] = ovf_ack;
  assign ie_v[FLG_CMP]  = ctrl_q.cmp_ie;
  assign ie_v[FLG_OVF]  = ctrl_q.ovf_ie;

  for (genvar i = 0; i < N_FLAG; i++) begin : g_flag
    pwm_tc_flag u_flag (
      .clk(clk), .rst_n(rst_n), .set_evt(evt_v[i]), .ack(ack_v[i]),
      .enable(ie_v[i]), .flag_q(flag_v[i]), .irq(irq_v[i])
    );
  end

  assign cmp_flag_o = flag_v[FLG_CMP];
  assign ovf_flag_o = flag_v[FLG_OVF];
  assign cmp_irq    = irq_v[FLG_CMP];
  assign ovf_irq    = irq_v[FLG_OVF];

endmodule

// File: rtl/pwm_tc_chk.sv
module pwm_tc_chk #(
  parameter int W = 8
) (
  input logic         clk,
  input logic         rst_n,
  input logic [1:0]   wm,
  input logic [W-1:0] count_o,
  input logic         cmp_evt,
  input logic         ovf_evt,
  input logic         cmp_ack,
  input logic         cmp_flag_o,
  input logic         ovf_flag_o,
  input logic         cmp_irq,
  input logic         pwm_o,
  input logic         pwm_oe
);

  localparam logic [W-1:0] MAXV = '1;

  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!wm[1]) |=> $stable(count_o)); // R2
  AST_FAST_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (wm == 2'b11) |=> (count_o == W'($past(count_o) + 1'b1))); // R3
  AST_DUAL_TURN: assert property (@(posedge clk) disable iff (!rst_n)
    (wm == 2'b10 && count_o == MAXV) |=> (count_o == MAXV - 1'b1)); // R4
  AST_CMP_SET: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_evt |=> cmp_flag_o); // R5
  AST_OVF_SET: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> ovf_flag_o); // R6
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    cmp_irq |-> cmp_flag_o); // R7
  AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (cmp_ack && !cmp_evt) |=> !cmp_flag_o); // R8
  AST_PIN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    (!pwm_oe) |-> !pwm_o); // R12

endmodule

bind pwm_tc pwm_tc_chk #(.W(W)) chk_i (
  .clk(clk), .rst_n(rst_n), .wm(wm_w), .count_o(count_o),
  .cmp_evt(cmp_evt_w), .ovf_evt(ovf_evt_w), .cmp_ack(cmp_ack),
  .cmp_flag_o(cmp_flag_o), .ovf_flag_o(ovf_flag_o), .cmp_irq(cmp_irq),
  .pwm_o(pwm_o), .pwm_oe(pwm_oe)
);

// File: tb/pwm_tc_tb.sv
module pwm_tc_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_addr = 1'b0;
  logic [7:0] wr_data = '0;
  logic       cmp_ack = 1'b0;
  logic       ovf_ack = 1'b0;
  logic [7:0] count_o;
  logic       pwm_o, pwm_oe, cmp_flag_o, ovf_flag_o, cmp_irq, ovf_irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  pwm_tc #(.W(8)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cmp_ack(cmp_ack), .ovf_ack(ovf_ack),
    .count_o(count_o), .pwm_o(pwm_o), .pwm_oe(pwm_oe),
    .cmp_flag_o(cmp_flag_o), .ovf_flag_o(ovf_flag_o),
    .cmp_irq(cmp_irq), .ovf_irq(ovf_irq)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic logic [7:0] ctrl(input int wm, input int om,
                                      input int cie, input int oie);
    return {2'b00, oie[0], cie[0], om[1:0], wm[1:0]};
  endfunction

  task automatic wr(input logic a, input logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic wait_cnt(input int v);
    while (int'(count_o) != v) @(negedge clk);
  endtask

  task automatic pulse_ack(input logic c, input logic o);
    cmp_ack = c; ovf_ack = o;
    @(negedge clk);
    cmp_ack = 1'b0; ovf_ack = 1'b0;
  endtask

  task automatic measure(input int per, output int hi);
    hi = 0;
    repeat (per) begin
      if (pwm_o) hi++;
      @(negedge clk);
    end
  endtask

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", WD_CYCLES, 0);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int mc, up, mcf, mof, c, hi, per, expv;
    @(negedge clk);
    do_reset();
    // R1 reset state
    chk("R1 count", count_o, 0);
    chk("R1 cmp flag", cmp_flag_o, 0);
    chk("R1 ovf flag", ovf_flag_o, 0);
    chk("R1 irqs", {cmp_irq, ovf_irq}, 0);
    chk("R1 pin", {pwm_o, pwm_oe}, 0);
    repeat (10) @(negedge clk);
    chk("R2 halted after reset count", count_o, 0);
    chk("R2 halted flags", {cmp_flag_o, ovf_flag_o}, 0);

    // R3/R5/R6 sawtooth tracking
    wr(1'b1, 8'd100);
    wr(1'b0, ctrl(3, 0, 0, 0));
    mc = 0; mcf = 0; mof = 0;
    for (int i = 0; i < 600; i++) begin
      chk("R3 sawtooth count", count_o, mc);
      chk("R5 cmp flag sawtooth", cmp_flag_o, mcf);
      chk("R6 ovf flag sawtooth", ovf_flag_o, mof);
      if (mc == 100) mcf = 1;
      if (mc == 255) mof = 1;
      mc = (mc + 1) % 256;
      @(negedge clk);
    end

    // R4/R5/R6 triangle tracking
    do_reset();
    wr(1'b1, 8'd100);
    wr(1'b0, ctrl(2, 0, 0, 0));
    mc = 0; up = 1; mcf = 0; mof = 0;
    for (int i = 0; i < 1100; i++) begin
      chk("R4 triangle count", count_o, mc);
      chk("R5 cmp flag triangle", cmp_flag_o, mcf);
      chk("R6 ovf flag triangle", ovf_flag_o, mof);
      if (mc == 100) mcf = 1;
      if (mc == 0 && up == 0) mof = 1;
      if (mc == 0) up = 1;
      else if (mc == 255) up = 0;
      mc = (up == 1) ? mc + 1 : mc - 1;
      @(negedge clk);
    end

    // R7 interrupt gating
    chk("R7 irqs off with enables clear", {cmp_irq, ovf_irq}, 0);
    wr(1'b0, ctrl(2, 0, 1, 1));
    chk("R7 both irqs enabled", {cmp_irq, ovf_irq}, 3);
    wr(1'b0, ctrl(2, 0, 1, 0));
    chk("R7 ovf irq masked", {cmp_irq, ovf_irq}, 2);

    // R8 acknowledge
    wait_cnt(20);
    pulse_ack(1'b1, 1'b1);
    chk("R8 ack clears flags", {cmp_flag_o, ovf_flag_o}, 0);
    chk("R8 irq drops with flag", cmp_irq, 0);
    wait_cnt(100);
    pulse_ack(1'b1, 1'b0);
    chk("R8 cmp set beats ack", cmp_flag_o, 1);
    wait_cnt(0);
    pulse_ack(1'b0, 1'b1);
    chk("R8 ovf set beats ack", ovf_flag_o, 1);

    // R11 double buffer, sawtooth
    do_reset();
    wr(1'b1, 8'd200);
    wr(1'b0, ctrl(3, 0, 0, 0));
    wait_cnt(10);
    wr(1'b1, 8'd50);
    wait_cnt(60);
    chk("R11 sawtooth new value not yet active", cmp_flag_o, 0);
    wait_cnt(210);
    chk("R11 sawtooth old value still matches", cmp_flag_o, 1);
    pulse_ack(1'b1, 1'b0);
    wait_cnt(45);
    chk("R11 sawtooth after wrap below new", cmp_flag_o, 0);
    wait_cnt(52);
    chk("R11 sawtooth new value matches", cmp_flag_o, 1);

    // R11 double buffer, triangle
    do_reset();
    wr(1'b1, 8'd200);
    wr(1'b0, ctrl(2, 0, 0, 0));
    wait_cnt(10);
    wr(1'b1, 8'd50);
    wait_cnt(60);
    chk("R11 triangle new value not yet active", cmp_flag_o, 0);
    wait_cnt(230);
    chk("R11 triangle old value on way up", cmp_flag_o, 1);
    pulse_ack(1'b1, 1'b0);
    wait_cnt(150);
    chk("R11 triangle loaded at top", cmp_flag_o, 0);
    wait_cnt(40);
    chk("R11 triangle new value on way down", cmp_flag_o, 1);

    // R2 halt with mode 01, R11 halted pass-through
    wr(1'b0, ctrl(1, 0, 0, 0));
    c = count_o;
    pulse_ack(1'b1, 1'b1);
    repeat (20) @(negedge clk);
    chk("R2 halted count holds", count_o, c);
    chk("R2 halted no flags", {cmp_flag_o, ovf_flag_o}, 0);
    wr(1'b1, c[7:0]);
    wr(1'b0, ctrl(3, 0, 0, 0));
    chk("R11 halted write, no match yet", cmp_flag_o, 0);
    @(negedge clk);
    chk("R11 halted write took effect", cmp_flag_o, 1);
    chk("R3 resume step", count_o, (c + 1) % 256);

    // R12 disconnected output
    wr(1'b1, 8'd128);
    wr(1'b0, ctrl(3, 0, 0, 0));
    repeat (300) @(negedge clk);
    chk("R12 oe off mode 00", pwm_oe, 0);
    measure(256, hi);
    chk("R12 pin low mode 00", hi, 0);
    wr(1'b0, ctrl(3, 1, 0, 0));
    chk("R12 oe off mode 01", pwm_oe, 0);
    measure(256, hi);
    chk("R12 pin low mode 01", hi, 0);

    // R9/R10 duty sweeps
    for (int wm = 2; wm <= 3; wm++) begin
      for (int om = 2; om <= 3; om++) begin
        for (int k = 0; k <= 255; k += 15) begin
          wr(1'b1, k[7:0]);
          wr(1'b0, ctrl(wm, om, 0, 0));
          per = (wm == 3) ? 256 : 510;
          repeat (2 * per) @(negedge clk);
          chk("R12 oe on", pwm_oe, 1);
          measure(per, hi);
          if (wm == 3) begin
            expv = (om == 2) ? k : 256 - k;
            chk($sformatf("R9 sawtooth om=%0d k=%0d", om, k), hi, expv);
          end else begin
            expv = (om == 2) ? 2 * k : 510 - 2 * k;
            chk($sformatf("R10 triangle om=%0d k=%0d", om, k), hi, expv);
          end
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule